// File: doc/BRIEF.md
# Vertical Blank Flag and NMI Generator

This block sits on the video-timing side of a display pipeline. It keeps the vertical-blank status bit that the CPU reads, and it drives the active-low non-maskable interrupt request that marks the start of each blanking interval. A dot counter and a scanline counter walk a frame of fixed geometry. Each clock of `clk` is one video dot. CPU accesses reach the block as single-cycle strobes that are already aligned to dots.

A status read returns the vertical-blank bit as it stands and then clears it. The block resolves the race between a status read and the onset of vertical blank to the exact dot. A pending flag is raised one dot before the onset. A status read that lands on the onset dot consumes that pending flag. The read returns 0, the vertical-blank bit is not set for that frame, and no NMI follows. The interrupt output is low while both the vertical-blank bit and the control register's NMI-enable bit are set. Enabling NMI in the middle of blanking therefore raises it at once.

Top module: `vbl_nmi_gen`

## Requirements
- R1: Synchronous reset (`rst` high) returns the dot and scanline counters to 0 and clears the vertical-blank bit, the pending flag and the NMI-enable bit. During reset and on the first cycle after it, `stat_vbl` is 0 and `nmi_n` is 1.
- R2: The frame is `DOTS` dots by `LINES` scanlines, and position (line 0, dot 0) is the first cycle after reset. Vertical blank begins at dot `ONSET_DOT` of line `ONSET_LINE`. The vertical-blank bit becomes 1 at the clock edge that ends that dot.
- R3: A status read (`stat_rd` high) on the onset dot returns 0. The vertical-blank bit then stays 0 for the rest of that frame, and `nmi_n` stays 1.
- R4: A status read on the dot just before the onset returns 0 and does not suppress that frame's vertical-blank bit or NMI.
- R5: After the clock edge that ends a read dot, `stat_vbl` shows the vertical-blank bit as it was during that dot. The edge also clears the bit, so a second read returns 0.
- R6: The vertical-blank bit clears at the edge that ends dot `CLEAR_DOT` of line `CLEAR_LINE`.
- R7: `nmi_n` is a registered output. It is 0 exactly while the vertical-blank bit and the NMI-enable bit are both 1. It first goes low on the cycle after the onset dot.
- R8: If the enable bit is written to 0 on or before the dot that precedes the onset, no NMI is produced in that blanking interval.
- R9: A control write (`ctrl_wr` high) loads `ctrl_nmi_en` into the enable bit. If the vertical-blank bit is already set, `nmi_n` follows the new enable value on the next cycle.
- R10: A status read that clears the vertical-blank bit releases `nmi_n` on the next cycle.
- R11: `stat_vbl` keeps its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock, one dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | Status-register read strobe for the current dot |
| ctrl_wr | input | 1 | Control-register write strobe for the current dot |
| ctrl_nmi_en | input | 1 | NMI-enable value carried by a control write |
| stat_vbl | output | 1 | Vertical-blank bit (bit 7) returned by the last status read |
| nmi_n | output | 1 | Active-low NMI request |

## Verification
The bench places status reads on the dot before the onset, on the onset dot and well after it. These three cases separate a correct one-dot pending window from designs that set the flag early, late, or without the cancel path. Control writes are placed just before the onset, inside blanking and across the clear dot. They show whether the interrupt follows the enable bit level, not a latched edge. A reset in the middle of blanking shows that the enable bit does not survive reset. A behavioural model advanced on every clock catches any drift in the frame geometry between the named checks.

// File: rtl/vbl_nmi_pkg.sv
package vbl_nmi_pkg;

  // default frame geometry
  localparam int DEF_DOTS        = 341;
  localparam int DEF_LINES       = 262;
  localparam int DEF_ONSET_LINE  = 241;
  localparam int DEF_ONSET_DOT   = 1;
  localparam int DEF_CLEAR_LINE  = 261;
  localparam int DEF_CLEAR_DOT   = 1;

  // one-dot strobes decoded from the raster position
  typedef struct packed {
    logic pre;    // dot just before blanking onset
    logic onset;  // blanking onset dot
    logic clear;  // flag clear dot
  } frame_evt_t;

endpackage

// File: rtl/vbl_dot_counter.sv
module vbl_dot_counter
  import vbl_nmi_pkg::*;
#(
  parameter int DOTS       = DEF_DOTS,
  parameter int LINES      = DEF_LINES,
  parameter int ONSET_LINE = DEF_ONSET_LINE,
  parameter int ONSET_DOT  = DEF_ONSET_DOT,
  parameter int CLEAR_LINE = DEF_CLEAR_LINE,
  parameter int CLEAR_DOT  = DEF_CLEAR_DOT
) (
  input  logic       clk,
  input  logic       rst,
  output frame_evt_t evt
);

  localparam int X_W = (DOTS  > 1) ? $clog2(DOTS)  : 1;
  localparam int Y_W = (LINES > 1) ? $clog2(LINES) : 1;

  // the dot before onset may sit on the previous line
  localparam int PRE_DOT_I  = (ONSET_DOT == 0) ? DOTS - 1 : ONSET_DOT - 1;
  localparam int PRE_LINE_I = (ONSET_DOT != 0) ? ONSET_LINE :
                              ((ONSET_LINE == 0) ? LINES - 1 : ONSET_LINE - 1);

  localparam logic [X_W-1:0] X_LAST  = X_W'(DOTS - 1);
  localparam logic [Y_W-1:0] Y_LAST  = Y_W'(LINES - 1);
  localparam logic [X_W-1:0] X_PRE   = X_W'(PRE_DOT_I);
  localparam logic [Y_W-1:0] Y_PRE   = Y_W'(PRE_LINE_I);
  localparam logic [X_W-1:0] X_ONSET = X_W'(ONSET_DOT);
  localparam logic [Y_W-1:0] Y_ONSET = Y_W'(ONSET_LINE);
  localparam logic [X_W-1:0] X_CLEAR = X_W'(CLEAR_DOT);
  localparam logic [Y_W-1:0] Y_CLEAR = Y_W'(CLEAR_LINE);

  logic [X_W-1:0] dot_q;
  logic [Y_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (dot_q == X_LAST) begin
      dot_q  <= '0;
      line_q <= (line_q == Y_LAST) ? '0 : line_q + 1'b1;
    end else begin
      dot_q  <= dot_q + 1'b1;
    end
  end

  always_comb begin
    evt.pre   = (line_q == Y_PRE)   && (dot_q == X_PRE);
    evt.onset = (line_q == Y_ONSET) && (dot_q == X_ONSET);
    evt.clear = (line_q == Y_CLEAR) && (dot_q == X_CLEAR);
  end

endmodule

// File: rtl/vbl_flag_ctrl.sv
module vbl_flag_ctrl
  import vbl_nmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  frame_evt_t evt,
  input  logic       rd,
  output logic       vbl_q,
  output logic       vbl_d,
  output logic       pend_q,
  output logic       rd_vbl_q
);

  logic pend_d;

  // pending is live only during the onset dot; a read there consumes it
  always_comb begin
    if (evt.pre)
      pend_d = 1'b1;
    else if (evt.onset || rd)
      pend_d = 1'b0;
    else
      pend_d = pend_q;
  end

  always_comb begin
    vbl_d = vbl_q;
    if (evt.onset)
      vbl_d = pend_q && !rd;
    else if (evt.clear || rd)
      vbl_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      vbl_q    <= 1'b0;
      rd_vbl_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      vbl_q  <= vbl_d;
      if (rd)
        rd_vbl_q <= vbl_q;
    end
  end

endmodule

// File: rtl/vbl_nmi_out.sv
module vbl_nmi_out (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_en_bit,
  input  logic vbl_d,
  output logic en_q,
  output logic nmi_n
);

  logic en_d;

  always_comb en_d = wr ? wr_en_bit : en_q;

  // registered from next-state values so the pin lines up with the flag
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      nmi_n <= 1'b1;
    end else begin
      en_q  <= en_d;
      nmi_n <= !(en_d && vbl_d);
    end
  end

endmodule

// File: rtl/vbl_nmi_gen.sv
module vbl_nmi_gen
  import vbl_nmi_pkg::*;
#(
  parameter int DOTS       = DEF_DOTS,
  parameter int LINES      = DEF_LINES,
  parameter int ONSET_LINE = DEF_ONSET_LINE,
  parameter int ONSET_DOT  = DEF_ONSET_DOT,
  parameter int CLEAR_LINE = DEF_CLEAR_LINE,
  parameter int CLEAR_DOT  = DEF_CLEAR_DOT
) (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic ctrl_wr,
  input  logic ctrl_nmi_en,
  output logic stat_vbl,
  output logic nmi_n
);

  frame_evt_t evt;
  logic       vbl_q;
  logic       vbl_d;
  logic       pend_q;
  logic       nmi_en_q;

  vbl_dot_counter #(
    .DOTS(DOTS), .LINES(LINES),
    .ONSET_LINE(ONSET_LINE), .ONSET_DOT(ONSET_DOT),
    .CLEAR_LINE(CLEAR_LINE), .CLEAR_DOT(CLEAR_DOT)
  ) raster_i (
    .clk (clk),
    .rst (rst),
    .evt (evt)
  );

  vbl_flag_ctrl flag_i (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .rd       (stat_rd),
    .vbl_q    (vbl_q),
    .vbl_d    (vbl_d),
    .pend_q   (pend_q),
    .rd_vbl_q (stat_vbl)
  );

  vbl_nmi_out nmi_i (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctrl_wr),
    .wr_en_bit (ctrl_nmi_en),
    .vbl_d     (vbl_d),
    .en_q      (nmi_en_q),
    .nmi_n     (nmi_n)
  );

endmodule

// File: rtl/vbl_nmi_gen_chk.sv
module vbl_nmi_gen_chk (
  input logic clk,
  input logic rst,
  input logic stat_rd,
  input logic stat_vbl,
  input logic nmi_n,
  input logic vbl_q,
  input logic pend_q,
  input logic nmi_en_q
);

  // R1: reset releases the interrupt and clears the read data
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (nmi_n && !stat_vbl && !vbl_q && !pend_q && !nmi_en_q));

  // R3: read while pending leaves the flag clear
  assert_onset_read_suppress_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && stat_rd) |=> (!vbl_q && nmi_n));

  // R5: read returns the flag seen on its dot
  assert_read_data_R5: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (stat_vbl == $past(vbl_q)));

  // R5: any read leaves the flag clear
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !vbl_q);

  // R7: interrupt low only with flag and enable both set
  assert_nmi_level_R7: assert property (@(posedge clk) disable iff (rst)
    !nmi_n |-> (vbl_q && nmi_en_q));

  // R7: flag and enable both set means interrupt low
  assert_nmi_active_R7: assert property (@(posedge clk) disable iff (rst)
    (vbl_q && nmi_en_q) |-> !nmi_n);

  // R11: read data holds without a read
  assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> $stable(stat_vbl));

endmodule

bind vbl_nmi_gen vbl_nmi_gen_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .stat_rd  (stat_rd),
  .stat_vbl (stat_vbl),
  .nmi_n    (nmi_n),
  .vbl_q    (vbl_q),
  .pend_q   (pend_q),
  .nmi_en_q (nmi_en_q)
);

// File: tb/vbl_nmi_gen_tb_top.sv
`timescale 1ns/1ps
module vbl_nmi_gen_tb_top;

  localparam int W  = 20;
  localparam int H  = 12;
  localparam int VL = 8;
  localparam int VD = 1;
  localparam int CL = 11;
  localparam int CD = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stat_rd = 1'b0;
  logic ctrl_wr = 1'b0;
  logic ctrl_nmi_en = 1'b0;
  logic stat_vbl;
  logic nmi_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int mx = 0, my = 0;
  bit mv = 0, mp = 0, me = 0, ms = 0, mn = 1;

  always #2.5 clk = ~clk;

  vbl_nmi_gen #(
    .DOTS(W), .LINES(H), .ONSET_LINE(VL), .ONSET_DOT(VD),
    .CLEAR_LINE(CL), .CLEAR_DOT(CD)
  ) dut_i (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .ctrl_wr(ctrl_wr),
    .ctrl_nmi_en(ctrl_nmi_en), .stat_vbl(stat_vbl), .nmi_n(nmi_n)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at line %0d dot %0d: actual %b expected %b", req, my, mx, act, exp);
    end
  endtask

  // behavioural frame model, one step per dot
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mx = 0; my = 0; mv = 0; mp = 0; me = 0; ms = 0; mn = 1;
    end else begin
      bit onset, clr, pre;
      onset = (my == VL) && (mx == VD);
      clr   = (my == CL) && (mx == CD);
      pre   = (my == VL) && (mx == VD - 1);
      if (stat_rd) ms = mv;
      if (onset) mv = mp && !stat_rd;
      else if (clr || stat_rd) mv = 0;
      mp = pre;
      if (ctrl_wr) me = ctrl_nmi_en;
      mn = !(mv && me);
      if (mx == W - 1) begin
        mx = 0;
        my = (my == H - 1) ? 0 : my + 1;
      end else mx = mx + 1;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cyc >= 2) begin
      chk("R5", stat_vbl, ms);
      chk("R7", nmi_n, mn);
    end
  end

  task automatic goto(int l, int d);
    while (!(my == l && mx == d)) @(negedge clk);
  endtask

  task automatic do_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic do_write(logic v);
    ctrl_wr = 1'b1;
    ctrl_nmi_en = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", stat_vbl, 1'b0);
    chk("R1", nmi_n, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", nmi_n, 1'b1);

    // frame 1: plain onset, read afterwards
    do_write(1'b1);
    goto(VL, VD);
    chk("R2", nmi_n, 1'b1);
    @(negedge clk);
    chk("R7", nmi_n, 1'b0);
    goto(VL, 5);
    do_read();
    chk("R2", stat_vbl, 1'b1);
    chk("R10", nmi_n, 1'b1);
    repeat (3) @(negedge clk);
    chk("R11", stat_vbl, 1'b1);
    goto(VL + 1, 0);
    do_read();
    chk("R5", stat_vbl, 1'b0);

    // frame 2: read one dot before onset
    goto(VL, VD - 1);
    do_read();
    chk("R4", stat_vbl, 1'b0);
    @(negedge clk);
    chk("R4", nmi_n, 1'b0);
    goto(VL, 6);
    do_read();
    chk("R4", stat_vbl, 1'b1);

    // frame 3: read exactly on the onset dot
    goto(VL, VD);
    do_read();
    chk("R3", stat_vbl, 1'b0);
    chk("R3", nmi_n, 1'b1);
    goto(VL + 1, 0);
    chk("R3", nmi_n, 1'b1);
    do_read();
    chk("R3", stat_vbl, 1'b0);

    // frame 4: enable dropped just before onset, then toggled
    goto(VL, VD - 1);
    do_write(1'b0);
    goto(VL, 3);
    chk("R8", nmi_n, 1'b1);
    goto(VL + 1, 3);
    do_write(1'b1);
    chk("R9", nmi_n, 1'b0);
    do_write(1'b0);
    chk("R9", nmi_n, 1'b1);
    goto(VL + 2, 0);
    do_write(1'b1);
    chk("R9", nmi_n, 1'b0);
    goto(CL, CD);
    chk("R6", nmi_n, 1'b0);
    @(negedge clk);
    chk("R6", nmi_n, 1'b1);
    do_read();
    chk("R6", stat_vbl, 1'b0);

    // frame 5: reset inside blanking
    goto(VL + 1, 0);
    chk("R7", nmi_n, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", nmi_n, 1'b1);
    chk("R1", stat_vbl, 1'b0);
    rst = 1'b0;
    goto(VL, VD + 1);
    chk("R1", nmi_n, 1'b1);
    goto(VL, 5);
    do_read();
    chk("R2", stat_vbl, 1'b1);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule